// File: doc/BRIEF.md
# Windowed Watchdog Timer with Restart Key

This block is a watchdog counter whose behaviour is fixed by a static option byte that is held stable while the block runs. The option byte holds three things: an enable bit, a 3-bit overflow select and a 2-bit window select. When the watchdog is enabled it starts counting as soon as reset is released. Software must restart it by writing the key value 0xAC into a write-only key register before the selected period runs out.

The first key write after reset may come at any point before overflow. Every later key write must land inside the open window, which is the final fraction of the period chosen by the window select. The block raises a one-cycle internal reset request in any of these cases:

- the period runs out;
- the key value is wrong;
- the key register is written by a single-bit read-modify-write, which the bit-operation qualifier flags;
- a key write arrives while the window is closed;
- the external illegal-access flag is asserted.

After a request, the counter and the first-write exemption both return to their reset state.

Top module: `keyed_window_wdt`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `rst_req` is 0. The counter starts from zero.
- R2: When option bit 4 is 0, `rst_req` never rises. Key writes, bit-operation writes, the illegal-access input and the passing of time all have no effect.
- R3: Option bits 3:1 select a code c from 0 to 7. The period is P = 2^(MIN_EXP+c) clock cycles, which is 2^(10+c) at the default. With no valid key write, `rst_req` pulses P cycles after reset release or after the last restart.
- R4: A key write of data 0xAC with `key_bitop` = 0 is valid when it is accepted. A valid write restarts the count from zero. It is accepted up to and including the last count P-1, and the next overflow then comes P cycles later.
- R5: The first key write after reset release, or after a reset request, is exempt from the window check.
- R6: Option bits 6:5 select a code w from 0 to 3. The window is open when count >= P - (w+1)·P/4. A non-exempt key write at a lower count raises `rst_req` in the next cycle.
- R7: A key write whose data is not 0xAC raises `rst_req` in the next cycle.
- R8: A key write with `key_bitop` = 1 raises `rst_req` in the next cycle, even when the data is 0xAC.
- R9: When the block is enabled, `illegal_acc` = 1 in a cycle raises `rst_req` in the next cycle.
- R10: `rst_req` is a one-cycle pulse for each cycle that holds a request event. While it is high, the count is zero and the first-write exemption is armed again. The next overflow follows P cycles after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_byte | input | 8 | Static option byte: bit 4 enable, bits 3:1 overflow code, bits 6:5 window code |
| key_wr | input | 1 | Key register write strobe |
| key_data | input | 8 | Data written to the key register |
| key_bitop | input | 1 | Marks the write as a single-bit read-modify-write |
| illegal_acc | input | 1 | External illegal-access flag |
| rst_req | output | 1 | Registered one-cycle internal reset request |

## Verification
The bench builds the block with MIN_EXP = 4, so the eight periods run from 16 to 2048 cycles. With periods that short, the bench can run every overflow to its end in a few thousand cycles, including the largest code. It can also reach the exact last count P-1 and the closed-to-open window boundary for each window code by counting edges. At the default MIN_EXP of 10, these same boundaries lie up to 131072 cycles away.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

  typedef struct packed {
    logic       en;
    logic [2:0] ovf_code;
    logic [1:0] win_code;
  } wdt_cfg_t;

  function automatic wdt_cfg_t decode_opt(input logic [6:1] opt);
    wdt_cfg_t c;
    c.en       = opt[4];
    c.ovf_code = opt[3:1];
    c.win_code = opt[6:5];
    return c;
  endfunction

  function automatic logic [31:0] period_of(input int min_exp, input logic [2:0] code);
    return 32'h1 << (min_exp + int'(code));
  endfunction

  function automatic logic [31:0] window_start(input logic [31:0] per, input logic [1:0] w);
    return per - (per >> 2) * (32'(w) + 32'd1);
  endfunction

endpackage

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (run)     count <= count + 1'b1;
  end

  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));

  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(count));

endmodule

// File: rtl/wwdt_window.sv
module wwdt_window
  import wwdt_pkg::*;
#(
  parameter int MIN_EXP = 10,
  parameter int CNT_W   = MIN_EXP + 7
) (
  input  wdt_cfg_t         cfg,
  input  logic [CNT_W-1:0] count,
  output logic             at_term,
  output logic             win_open
);

  logic [31:0] per;
  logic [31:0] open_from;
  logic [31:0] cnt_ext;

  assign per       = period_of(MIN_EXP, cfg.ovf_code);
  assign open_from = window_start(per, cfg.win_code);
  assign cnt_ext   = {{(32-CNT_W){1'b0}}, count};
  assign at_term   = (cnt_ext == per - 32'd1);
  assign win_open  = (cnt_ext >= open_from);

endmodule

// File: rtl/wwdt_judge.sv
module wwdt_judge #(
  parameter logic [7:0] KEY_VAL = 8'hAC
) (
  input  logic       en,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       key_bitop,
  input  logic       illegal_acc,
  input  logic       first_done,
  input  logic       win_open,
  input  logic       at_term,
  output logic       valid_clear,
  output logic       violation,
  output logic       overflow
);

  logic key_ok;
  logic in_time;

  assign key_ok      = (key_data == KEY_VAL) && !key_bitop;
  assign in_time     = !first_done || win_open;
  assign valid_clear = en && key_wr && key_ok && in_time;
  assign violation   = en && ((key_wr && (!key_ok || !in_time)) || illegal_acc);
  assign overflow    = en && at_term && !valid_clear;

endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt
  import wwdt_pkg::*;
#(
  parameter int         MIN_EXP = 10,
  parameter logic [7:0] KEY_VAL = 8'hAC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] opt_byte,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       key_bitop,
  input  logic       illegal_acc,
  output logic       rst_req
);

  localparam int CNT_W = MIN_EXP + 7;

  wdt_cfg_t         cfg;
  logic [CNT_W-1:0] count;
  logic             at_term;
  logic             win_open;
  logic             first_done;
  logic             valid_clear;
  logic             violation;
  logic             overflow;
  logic             event_req;
  logic             restart;
  logic             unused_opt;

  assign cfg        = decode_opt(opt_byte[6:1]);
  assign unused_opt = ^{opt_byte[7], opt_byte[0]};
  assign event_req  = violation || overflow;
  assign restart    = valid_clear || event_req;

  wwdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg.en),
    .restart (restart),
    .count   (count)
  );

  wwdt_window #(.MIN_EXP(MIN_EXP), .CNT_W(CNT_W)) win_i (
    .cfg      (cfg),
    .count    (count),
    .at_term  (at_term),
    .win_open (win_open)
  );

  wwdt_judge #(.KEY_VAL(KEY_VAL)) judge_i (
    .en          (cfg.en),
    .key_wr      (key_wr),
    .key_data    (key_data),
    .key_bitop   (key_bitop),
    .illegal_acc (illegal_acc),
    .first_done  (first_done),
    .win_open    (win_open),
    .at_term     (at_term),
    .valid_clear (valid_clear),
    .violation   (violation),
    .overflow    (overflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req    <= 1'b0;
      first_done <= 1'b0;
    end else begin
      rst_req <= event_req;
      if (event_req)        first_done <= 1'b0;
      else if (valid_clear) first_done <= 1'b1;
    end
  end

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> !rst_req);

  assert_overflow_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> rst_req);

  assert_valid_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_clear && !illegal_acc) |=> (count == '0 && !rst_req && first_done));

  assert_closed_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && key_wr && first_done && !win_open) |=> rst_req);

  assert_bad_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && key_wr && key_data != KEY_VAL) |=> rst_req);

  assert_bitop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && key_wr && key_bitop) |=> rst_req);

  assert_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && illegal_acc) |=> rst_req);

  assert_restart_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (count == '0 && !first_done));

endmodule

// File: tb/keyed_window_wdt_tb_top.sv
module keyed_window_wdt_tb_top;

  localparam int BEXP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opt_byte = 8'h00;
  logic       key_wr = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic       key_bitop = 1'b0;
  logic       illegal_acc = 1'b0;
  logic       rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyed_window_wdt #(.MIN_EXP(BEXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .opt_byte(opt_byte), .key_wr(key_wr),
    .key_data(key_data), .key_bitop(key_bitop), .illegal_acc(illegal_acc),
    .rst_req(rst_req)
  );

  typedef struct packed {
    logic [2:0] ovf;
    logic [1:0] win;
    logic [7:0] wait_n;
    logic [7:0] data;
    logic       bitop;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{3'd1, 2'd0, 8'd10, 8'hAC, 1'b0},
    '{3'd1, 2'd0, 8'd24, 8'hAC, 1'b0},
    '{3'd1, 2'd0, 8'd23, 8'hAC, 1'b0},
    '{3'd1, 2'd1, 8'd16, 8'hAC, 1'b0},
    '{3'd1, 2'd1, 8'd15, 8'hAC, 1'b0},
    '{3'd2, 2'd2, 8'd16, 8'hAC, 1'b0},
    '{3'd2, 2'd3, 8'd0,  8'hAC, 1'b0},
    '{3'd2, 2'd3, 8'd5,  8'h55, 1'b0},
    '{3'd2, 2'd3, 8'd5,  8'hAC, 1'b1},
    '{3'd0, 2'd0, 8'd15, 8'hAC, 1'b0}
  };

  function automatic logic [7:0] mk_opt(input logic en, input logic [2:0] ovf, input logic [1:0] win);
    return {1'b0, win, en, ovf, 1'b0};
  endfunction

  function automatic int per_len(input int code);
    int p = 1;
    for (int i = 0; i < BEXP + code; i++) p = p * 2;
    return p;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] opt);
    @(negedge clk);
    rst_n = 1'b0; opt_byte = opt; key_wr = 1'b0; key_bitop = 1'b0; illegal_acc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic key(input logic [7:0] d, input logic b);
    key_wr = 1'b1; key_data = d; key_bitop = b;
    @(negedge clk);
    key_wr = 1'b0; key_bitop = 1'b0;
  endtask

  task automatic edges_to_pulse(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rst_req && n < limit);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int seen;

    // R1: reset state
    opt_byte = mk_opt(1'b1, 3'd0, 2'd0);
    illegal_acc = 1'b1;
    idle(2);
    chk("R1 during reset", int'(rst_req), 0);
    illegal_acc = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(rst_req), 0);

    // Vector table: first write exempt (R5), then second write rules (R6 R7 R8)
    for (int v = 0; v < NVEC; v++) begin
      int p;
      int st;
      int ex;
      do_reset(mk_opt(1'b1, VEC[v].ovf, VEC[v].win));
      key(8'hAC, 1'b0);
      chk("R5 first write accepted", int'(rst_req), 0);
      idle(int'(VEC[v].wait_n));
      key(VEC[v].data, VEC[v].bitop);
      p  = per_len(int'(VEC[v].ovf));
      st = p - (p / 4) * (int'(VEC[v].win) + 1);
      ex = (VEC[v].bitop || VEC[v].data != 8'hAC || int'(VEC[v].wait_n) < st) ? 1 : 0;
      chk($sformatf("R6 R7 R8 vector %0d", v), int'(rst_req), ex);
    end

    // R3: overflow period for smallest and largest code, R10 single pulse and restart
    for (int c = 0; c < 8; c += 7) begin
      do_reset(mk_opt(1'b1, 3'(c), 2'd0));
      edges_to_pulse(5000, n);
      chk($sformatf("R3 period code %0d", c), n, per_len(c));
      @(negedge clk);
      chk("R10 pulse one cycle", int'(rst_req), 0);
      edges_to_pulse(5000, n);
      chk("R10 next overflow after event", n + 1, per_len(c));
    end

    // R4: clear at last count, first write and a windowed write
    do_reset(mk_opt(1'b1, 3'd0, 2'd0));
    idle(per_len(0) - 1);
    key(8'hAC, 1'b0);
    chk("R4 first clear at last count", int'(rst_req), 0);
    idle(per_len(0) - 1);
    key(8'hAC, 1'b0);
    chk("R4 windowed clear at last count", int'(rst_req), 0);
    edges_to_pulse(5000, n);
    chk("R4 overflow after clear", n, per_len(0));

    // R5 and R6: early first write exempt, early second write trips
    do_reset(mk_opt(1'b1, 3'd1, 2'd0));
    idle(1);
    key(8'hAC, 1'b0);
    chk("R5 early first write", int'(rst_req), 0);
    key(8'hAC, 1'b0);
    chk("R6 early second write", int'(rst_req), 1);

    // R7 wrong key as first write
    do_reset(mk_opt(1'b1, 3'd1, 2'd3));
    key(8'h00, 1'b0);
    chk("R7 wrong first key", int'(rst_req), 1);

    // R9 illegal access, then R10 exemption rearmed
    do_reset(mk_opt(1'b1, 3'd1, 2'd0));
    key(8'hAC, 1'b0);
    idle(3);
    illegal_acc = 1'b1;
    @(negedge clk);
    illegal_acc = 1'b0;
    chk("R9 illegal access", int'(rst_req), 1);
    @(negedge clk);
    chk("R10 illegal pulse ends", int'(rst_req), 0);
    key(8'hAC, 1'b0);
    chk("R10 exemption rearmed", int'(rst_req), 0);

    // R2: disabled block ignores everything
    do_reset(mk_opt(1'b0, 3'd0, 2'd0));
    seen = 0;
    key(8'h55, 1'b0); seen += int'(rst_req);
    key(8'hAC, 1'b1); seen += int'(rst_req);
    illegal_acc = 1'b1;
    for (int i = 0; i < 5 * per_len(0); i++) begin
      @(negedge clk);
      seen += int'(rst_req);
    end
    illegal_acc = 1'b0;
    chk("R2 disabled no request", seen, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule